// File: doc/BRIEF.md
# Four-Sequencer Sample Capture Front End

This block is the digital side of a sampling converter with four independent sample sequencers. Each sequencer owns a sixteen-entry result queue and a packed status word. When the shared trigger input is seen, a scan state machine visits the sequencers in ascending order. A sequencer takes part only when it is enabled in the enable register and its 4-bit event code selects the timer source. Each sequencer that takes part draws one value from a pseudo-random source, pushes it into its queue and raises its raw interrupt bit.

Software reaches the block through a simple synchronous register port. A global block holds the enable, event-code, interrupt and sticky error registers. Four windows, one per sequencer, hold a channel-select word, a control word, the queue pop port and the queue status. Each sequencer has its own interrupt output, which is its raw bit gated by its mask bit.

The scan machine has two states. In `SCAN_IDLE` it waits. The transition *start* (trigger sampled high) leads to `SCAN_WALK` with the index at 0. In `SCAN_WALK` the transition *advance* moves the index up by one each cycle. The transition *finish* leaves `SCAN_WALK` for `SCAN_IDLE` once the last index has been handled.

Top module: `adc_seq_frontend`

## Requirements
- R1: After reset, every queue status word reads 0x100 (empty only). The enable, raw interrupt, mask and sticky registers read 0, all interrupt outputs are low, and a read of an unwritten queue returns 0.
- R2: A queue status word places the read pointer in bits 3:0, the write pointer in bits 7:4, the empty flag in bit 8 and the full flag in bit 12. All other bits read 0, and empty and full are never set together.
- R3: A push into a full queue is dropped and the pointers stay put. A push into a queue that is not full clears empty and writes at the write pointer. It sets full when the advanced write pointer equals the read pointer.
- R4: A read of a queue data register (window offset 0x08) pops one entry in arrival order. The pop clears full and advances the read pointer modulo 16. Empty is set when the read pointer reaches the write pointer.
- R5: A trigger makes sequencer n push only when enable bit n (global 0x00) is set and event-code bits 4n+3:4n (global 0x14) equal 5. Sequencer n's window starts at 0x40 + 0x20·n.
- R6: Each push uses the value 0x200 plus bits 18:16 of the noise state. Just before each push, the noise state (0 after reset) is replaced by state × 314159 + 1 modulo 2^32. Pushing sequencers take values in ascending sequencer order.
- R7: The enable register keeps only its low 4 bits. A channel-select word (window offset 0x00) keeps only the bits in 0x33333333.
- R8: Interrupt output n equals raw bit n (global 0x04) AND mask bit n (global 0x08). A read of global 0x0C returns raw AND mask, and writing 1s to 0x0C clears those raw bits.
- R9: A read of an empty queue returns the entry at the current read pointer and changes neither pointer nor any flag.
- R10: A push into a full queue sets sticky overflow bit n (global 0x10). A read of an empty queue sets sticky underflow bit n (global 0x18). Writing 1s to either register clears those bits.
- R11: The edge that samples the trigger high starts a scan. Sequencer n's push and raw bit take effect n+1 edges later. Trigger samples taken while a scan is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Shared conversion trigger from the timer |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid after the edge that accepts the read |
| irq_o | output | 4 | Per-sequencer interrupt, raw AND mask |

## Verification
A register write takes effect at the edge that accepts it. Read data appears at that same edge, and a pop or underflow shows up in status from the next access onward. After the edge that samples the trigger high, sequencer n's queue and interrupt change one edge later per position, so n+1 edges after the trigger edge. All four have settled within five edges. The bench drives every input on the falling edge and samples outputs on the falling edge after the edge where each result is due. Interrupt timing is probed on the falling edges right after the trigger edge and the following edge. Queue contents are always read out after the scan has finished.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_WALK = 1'b1
    } scan_state_e;

    // global register offsets (low six address bits)
    localparam logic [5:0] G_ENABLE  = 6'h00;
    localparam logic [5:0] G_RAW     = 6'h04;
    localparam logic [5:0] G_MASK    = 6'h08;
    localparam logic [5:0] G_ICLR    = 6'h0C;
    localparam logic [5:0] G_OVF     = 6'h10;
    localparam logic [5:0] G_EVCODE  = 6'h14;
    localparam logic [5:0] G_UNF     = 6'h18;

    // per-sequencer window offsets
    localparam logic [4:0] W_CHSEL   = 5'h00;
    localparam logic [4:0] W_CTRL    = 5'h04;
    localparam logic [4:0] W_DATA    = 5'h08;
    localparam logic [4:0] W_STAT    = 5'h0C;

    // status word field positions
    localparam int STAT_WP_LSB = 4;
    localparam int STAT_EMPTY  = 8;
    localparam int STAT_FULL   = 12;

    localparam logic [31:0] CHSEL_KEEP = 32'h3333_3333;

endpackage

// File: rtl/adc_sample_queue.sv
module adc_sample_queue #(
    parameter int DEPTH    = 16,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [SAMPLE_W-1:0]        push_data_i,
    input  logic                       pop_i,
    output logic [SAMPLE_W-1:0]        head_o,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr_o,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic                       ovf_evt_o,
    output logic                       unf_evt_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SAMPLE_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]    rd_q, wr_q;
    logic                empty_q, full_q;
    logic                push_ok, pop_ok;
    logic [PTR_W-1:0]    rd_inc, wr_inc;

    assign push_ok = push_i && !full_q;
    assign pop_ok  = pop_i && !empty_q;
    assign rd_inc  = rd_q + PTR_W'(1);
    assign wr_inc  = wr_q + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
        end else begin
            if (push_ok) begin
                mem_q[wr_q] <= push_data_i;
                wr_q        <= wr_inc;
            end
            if (pop_ok) rd_q <= rd_inc;
            if (push_ok && !pop_ok) begin
                empty_q <= 1'b0;
                full_q  <= (wr_inc == rd_q);
            end else if (pop_ok && !push_ok) begin
                full_q  <= 1'b0;
                empty_q <= (rd_inc == wr_q);
            end
        end
    end

    assign head_o    = mem_q[rd_q];
    assign rd_ptr_o  = rd_q;
    assign wr_ptr_o  = wr_q;
    assign empty_o   = empty_q;
    assign full_o    = full_q;
    assign ovf_evt_o = push_i && full_q;
    assign unf_evt_o = pop_i && empty_q;

    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_q && full_q));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && push_i && !pop_i) |=> ($stable(wr_q) && full_q));
    p_pop_clears_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && pop_i && !push_i) |=> !full_q);
    p_empty_pop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_q && pop_i && !push_i) |=> ($stable(rd_q) && empty_q));
endmodule

// File: rtl/adc_noise_src.sv
module adc_noise_src #(
    parameter int          SAMPLE_W = 12,
    parameter logic [31:0] MULT     = 32'd314159,
    parameter int          BASE     = 'h200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    logic [31:0] state_q;
    logic [31:0] state_nxt;

    assign state_nxt = state_q * MULT + 32'd1;

    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= '0;
        else if (step_i) state_q <= state_nxt;
    end

    // sample drawn from the state as it will be after this step
    assign sample_o = SAMPLE_W'(BASE) + SAMPLE_W'(state_nxt[18:16]);

    p_noise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
endmodule

// File: rtl/adc_trig_scan.sv
module adc_trig_scan
    import adc_seq_pkg::*;
#(
    parameter int SEQ_N      = 4,
    parameter int TIMER_CODE = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    input  logic [SEQ_N-1:0]   enable_i,
    input  logic [4*SEQ_N-1:0] evcode_i,
    output logic [SEQ_N-1:0]   push_o,
    output logic               step_o
);
    localparam int IDX_W = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_N - 1);

    scan_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SCAN_IDLE: begin
                idx_d = '0;
                if (trig_i) state_d = SCAN_WALK;          // start
            end
            SCAN_WALK: begin
                if (idx_q == LAST) begin
                    state_d = SCAN_IDLE;                   // finish
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + IDX_W'(1);             // advance
                end
            end
            default: state_d = SCAN_IDLE;
        endcase
    end

    always_comb begin
        take   = 1'b0;
        push_o = '0;
        unique case (state_q)
            SCAN_IDLE: take = 1'b0;
            SCAN_WALK: take = enable_i[idx_q] &&
                              (evcode_i[4*idx_q +: 4] == 4'(TIMER_CODE));
            default:   take = 1'b0;
        endcase
        push_o[idx_q] = take;
        step_o        = take;
    end

    p_walk_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_WALK && idx_q == LAST) |=> state_q == SCAN_IDLE);
    p_walk_ignores_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_WALK && idx_q != LAST) |=> (state_q == SCAN_WALK && idx_q == $past(idx_q) + IDX_W'(1)));
    p_push_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_o) && (push_o == '0 || state_q == SCAN_WALK));
endmodule

// File: rtl/adc_seq_frontend.sv
module adc_seq_frontend
    import adc_seq_pkg::*;
#(
    parameter int SEQ_N      = 4,
    parameter int DEPTH      = 16,
    parameter int SAMPLE_W   = 12,
    parameter int TIMER_CODE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic [7:0]       req_addr_i,
    input  logic [31:0]      req_wdata_i,
    output logic [31:0]      rsp_rdata_o,
    output logic [SEQ_N-1:0] irq_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int EV_W  = 4 * SEQ_N;

    // address decode
    logic [2:0] blk;
    logic       in_glob, in_win;
    logic [1:0] win_idx;
    logic [4:0] win_reg;
    logic       wr_en, rd_en;

    assign blk     = req_addr_i[7:5] - 3'd2;
    assign in_win  = (blk < 3'd4) && (32'(blk) < SEQ_N);
    assign win_idx = blk[1:0];
    assign win_reg = req_addr_i[4:0];
    assign in_glob = (req_addr_i[7:6] == 2'b00);
    assign wr_en   = req_valid_i && req_write_i;
    assign rd_en   = req_valid_i && !req_write_i;

    // global registers
    logic [SEQ_N-1:0] enable_q, mask_q, raw_q, ovf_q, unf_q;
    logic [EV_W-1:0]  evcode_q;
    logic [SEQ_N-1:0] push_vec, ovf_evt, unf_evt, pop_vec, clr_vec;
    logic             step;
    logic [SAMPLE_W-1:0] sample;

    // per-sequencer state
    logic [31:0]         chsel_q [SEQ_N];
    logic [31:0]         ctrl_q  [SEQ_N];
    logic [SAMPLE_W-1:0] head    [SEQ_N];
    logic [31:0]         stat    [SEQ_N];

    assign clr_vec = (wr_en && in_glob && req_addr_i[5:0] == G_ICLR) ?
                     req_wdata_i[SEQ_N-1:0] : '0;

    adc_trig_scan #(.SEQ_N(SEQ_N), .TIMER_CODE(TIMER_CODE)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .enable_i (enable_q),
        .evcode_i (evcode_q),
        .push_o   (push_vec),
        .step_o   (step)
    );

    adc_noise_src #(.SAMPLE_W(SAMPLE_W)) u_noise (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .sample_o (sample)
    );

    for (genvar n = 0; n < SEQ_N; n++) begin : g_seq
        logic [PTR_W-1:0] rp, wp;
        logic             emp, ful;

        assign pop_vec[n] = rd_en && in_win && (win_idx == 2'(n)) && (win_reg == W_DATA);

        adc_sample_queue #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_queue (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (push_vec[n]),
            .push_data_i (sample),
            .pop_i       (pop_vec[n]),
            .head_o      (head[n]),
            .rd_ptr_o    (rp),
            .wr_ptr_o    (wp),
            .empty_o     (emp),
            .full_o      (ful),
            .ovf_evt_o   (ovf_evt[n]),
            .unf_evt_o   (unf_evt[n])
        );

        assign stat[n] = (32'(ful) << STAT_FULL) | (32'(emp) << STAT_EMPTY) |
                         (32'(wp) << STAT_WP_LSB) | 32'(rp);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chsel_q[n] <= '0;
                ctrl_q[n]  <= '0;
            end else if (wr_en && in_win && win_idx == 2'(n)) begin
                if (win_reg == W_CHSEL) chsel_q[n] <= req_wdata_i & CHSEL_KEEP;
                if (win_reg == W_CTRL)  ctrl_q[n]  <= req_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mask_q   <= '0;
            raw_q    <= '0;
            ovf_q    <= '0;
            unf_q    <= '0;
            evcode_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | push_vec;
            ovf_q <= (ovf_q & ~((wr_en && in_glob && req_addr_i[5:0] == G_OVF) ?
                                req_wdata_i[SEQ_N-1:0] : '0)) | ovf_evt;
            unf_q <= (unf_q & ~((wr_en && in_glob && req_addr_i[5:0] == G_UNF) ?
                                req_wdata_i[SEQ_N-1:0] : '0)) | unf_evt;
            if (wr_en && in_glob) begin
                unique case (req_addr_i[5:0])
                    G_ENABLE: enable_q <= req_wdata_i[SEQ_N-1:0];
                    G_MASK:   mask_q   <= req_wdata_i[SEQ_N-1:0];
                    G_EVCODE: evcode_q <= req_wdata_i[EV_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    // read path
    logic [31:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (in_glob) begin
            unique case (req_addr_i[5:0])
                G_ENABLE: rd_val = 32'(enable_q);
                G_RAW:    rd_val = 32'(raw_q);
                G_MASK:   rd_val = 32'(mask_q);
                G_ICLR:   rd_val = 32'(raw_q & mask_q);
                G_OVF:    rd_val = 32'(ovf_q);
                G_EVCODE: rd_val = 32'(evcode_q);
                G_UNF:    rd_val = 32'(unf_q);
                default:  rd_val = '0;
            endcase
        end else if (in_win) begin
            unique case (win_reg)
                W_CHSEL: rd_val = chsel_q[win_idx];
                W_CTRL:  rd_val = ctrl_q[win_idx];
                W_DATA:  rd_val = 32'(head[win_idx]);
                W_STAT:  rd_val = stat[win_idx];
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rsp_rdata_o <= '0;
        else if (rd_en) rsp_rdata_o <= rd_val;
    end

    assign irq_o = raw_q & mask_q;

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((raw_q & $past(clr_vec & ~push_vec)) == '0));
    p_push_sets_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vec != '0) |=> ((raw_q & $past(push_vec)) == $past(push_vec)));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && in_glob && req_addr_i[5:0] == G_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
    p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && in_glob && req_addr_i[5:0] == G_UNF) |=> ((unf_q & $past(unf_q)) == $past(unf_q)));
endmodule

// File: tb/adc_seq_frontend_test.sv
`timescale 1ns/1ps
module adc_seq_frontend_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] noise_m = '0;
    logic [31:0] q_exp [$];
    logic [31:0] fill_first;
    logic [31:0] v;

    always #4 clk = ~clk;

    adc_seq_frontend uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_sample();
        noise_m = noise_m * 32'd314159 + 32'd1;
        return 32'h200 + 32'((noise_m >> 16) & 32'd7);
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rdata;
        req_valid = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 32'h0);
        for (int n = 0; n < 4; n++) begin
            rd(8'(8'h4C + 8'(32 * n)), v);
            chk("R1 status", v, 32'h100);
        end
        rd(8'h00, v); chk("R1 enable", v, 0);
        rd(8'h04, v); chk("R1 raw", v, 0);
        rd(8'h10, v); chk("R1 ovf", v, 0);
    endtask

    task automatic t_masks();
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R7 enable width", v, 32'hF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R7 chsel mask", v, 32'h3333_3333);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_eligible();
        logic [31:0] s0, s2;
        wr(8'h14, 32'h0000_0535);
        wr(8'h00, 32'h7);
        pulse_trig();
        s0 = next_sample();
        s2 = next_sample();
        rd(8'h4C, v); chk("R5 seq0 pushed", v, 32'h010);
        rd(8'h6C, v); chk("R5 seq1 wrong code", v, 32'h100);
        rd(8'h8C, v); chk("R5 seq2 pushed", v, 32'h010);
        rd(8'hAC, v); chk("R5 seq3 disabled", v, 32'h100);
        rd(8'h04, v); chk("R5 raw bits", v, 32'h5);
        rd(8'h48, v); chk("R6 seq0 value", v, s0);
        rd(8'h88, v); chk("R6 seq2 value", v, s2);
        rd(8'h4C, v); chk("R4 seq0 empty after pop", v, 32'h111);
    endtask

    task automatic t_irq();
        wr(8'h08, 32'h1);
        @(negedge clk); chk("R8 irq gated", 32'(irq), 32'h1);
        rd(8'h0C, v); chk("R8 masked read", v, 32'h1);
        wr(8'h0C, 32'h1);
        rd(8'h04, v); chk("R8 clear raw", v, 32'h4);
        chk("R8 irq after clear", 32'(irq), 32'h0);
        wr(8'h0C, 32'hF);
    endtask

    task automatic t_fill();
        wr(8'h14, 32'h0000_0005);
        wr(8'h00, 32'h1);
        for (int i = 0; i < 16; i++) begin
            pulse_trig();
            q_exp.push_back(next_sample());
        end
        rd(8'h4C, v); chk("R3 full wrap", v, 32'h1011);
        pulse_trig();
        void'(next_sample());
        rd(8'h4C, v); chk("R3 push dropped", v, 32'h1011);
        rd(8'h10, v); chk("R10 overflow sticky", v, 32'h1);
        wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R10 overflow cleared", v, 32'h0);
        fill_first = q_exp[0];
        for (int i = 0; i < 16; i++) begin
            rd(8'h48, v); chk("R4 pop order", v, q_exp.pop_front());
            if (i == 0) begin
                rd(8'h4C, v); chk("R4 full cleared", v, 32'h012);
            end
        end
        rd(8'h4C, v); chk("R4 drained", v, 32'h111);
    endtask

    task automatic t_underflow();
        rd(8'h48, v); chk("R9 empty read value", v, fill_first);
        rd(8'h4C, v); chk("R9 pointers held", v, 32'h111);
        rd(8'h18, v); chk("R10 underflow sticky", v, 32'h1);
        rd(8'hA8, v); chk("R1 unwritten queue", v, 32'h0);
        rd(8'h18, v); chk("R10 underflow seq3", v, 32'h9);
        wr(8'h18, 32'hF);
        rd(8'h18, v); chk("R10 underflow cleared", v, 32'h0);
    endtask

    task automatic t_trig_hold();
        logic [31:0] s;
        wr(8'h0C, 32'hF);
        wr(8'h08, 32'h1);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); chk("R11 no push at trigger edge", 32'(irq), 32'h0);
        @(negedge clk); chk("R11 seq0 push one edge later", 32'(irq), 32'h1);
        @(negedge clk); trig = 1'b0;
        repeat (6) @(negedge clk);
        s = next_sample();
        rd(8'h4C, v); chk("R11 single push while held", v, 32'h021);
        rd(8'h48, v); chk("R11 value", v, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_eligible();
        t_irq();
        t_fill();
        t_underflow();
        t_trig_hold();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule